// File: doc/BRIEF.md
# Non-Volatile SRAM Store and Recall Controller

This block sits between the external pins of a battery-free non-volatile SRAM and two internal arrays: a fast volatile word array that serves ordinary reads and writes, and a shadow non-volatile array of the same depth. While idle, the block acts as a plain static RAM behind chip enable, write enable and output enable. On request it copies the whole volatile array into the shadow array (STORE), or copies it back (RECALL). Each copy runs word by word, and each word takes a configurable number of cycles.

A STORE has three possible sources: a falling edge on the hardware store pin, a rising power-fail flag (when automatic store is enabled), or a software command. A RECALL starts when the supply-good flag rises, or from a software command. A software command is three consecutive reads: two key addresses followed by an operation address. A STORE erases the shadow array before it copies. A RECALL clears the volatile array before it copies. While a transfer runs, all port accesses are locked out. After power comes up, the port stays deselected until chip enable has been seen high and has then fallen. The address of the last accepted write is always visible on an output.

Top module: `nvsram_ctrl`

## Requirements
- R1: While rst_n is low, busy_n is 1, dout_oe is 0 and last_wr_addr is 0.
- R2: While pwr_good is 0, no access takes effect and dout_oe stays 0. After pwr_good rises, accesses are ignored until ce_n has been sampled high and is then low.
- R3: In normal mode, a write (ce_n=0, we_n=0) stores din at addr on the clock edge. A read (ce_n=0, we_n=1, oe_n=0) drives the stored word on dout in the same cycle, with dout_oe=1.
- R4: last_wr_addr takes the address of each accepted write and changes at no other time.
- R5: A STORE holds busy_n low for exactly 2·2^AW·XFER_LAT cycles (64 by default), starting the cycle after the request. Afterwards the shadow array holds the volatile contents.
- R6: A RECALL holds busy_n low for 2·2^AW·XFER_LAT cycles. It first clears the volatile words in ascending order and then loads them from the shadow array.
- R7: While busy_n is 0, dout_oe is 0 and port writes are ignored.
- R8: The three reads 0xA, 0x5, then an operation address form a command. The operation addresses are 0x3 for STORE, 0xC for RECALL, 0x7 to enable power-fail store and 0x8 to disable it. Any write, or any other address, restarts the sequence.
- R9: A falling edge of hs_n while idle and powered starts a STORE.
- R10: A rising edge of pwr_fail while idle starts a STORE only when power-fail store is enabled (enabled after reset).
- R11: A rising edge of pwr_good starts a RECALL.
- R12: If a STORE and a RECALL are requested in the same cycle, the STORE runs. Requests that arrive while busy are dropped.
- R13: A rising edge of pwr_fail (when enabled) during a software RECALL aborts it, and busy_n is 1 in the next cycle.
- R14: A write accepted in the same cycle that pwr_fail rises completes, and the STORE that follows saves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply-good flag from the power monitor |
| pwr_fail | input | 1 | Supply-falling flag from the power monitor |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dout_oe | output | 1 | Data output enable (0 means high impedance) |
| hs_n | input | 1 | Hardware store request, falling edge |
| busy_n | output | 1 | Low while a STORE or RECALL runs |
| last_wr_addr | output | AW | Address of the last accepted write |

## Verification
On every cycle, the assertions check the output lockout during transfers and during power-down. They also check that last_wr_addr only moves after an accepted write, that a hardware store edge starts a transfer in the next cycle, and that a power-fail edge ends a software recall one cycle later. Other behaviours can only be shown by the bench's scenarios, which read data back after a recall: that erase and clear come before the copies, the exact busy length, the arming rule for chip enable, command decoding, STORE priority over RECALL, and a write that coincides with power failure still being saved.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ERASE = 3'd1,
      PH_SCOPY = 3'd2,
      PH_CLEAR = 3'd3,
      PH_RCOPY = 3'd4
   } xfer_ph_t;

   function automatic xfer_ph_t next_phase(input xfer_ph_t ph);
      case (ph)
         PH_ERASE: return PH_SCOPY;
         PH_CLEAR: return PH_RCOPY;
         default:  return PH_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/nvsram_ce_gate.sv
module nvsram_ce_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic ce_n,
   output logic ce_ok
);
   logic seen_hi;
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_hi <= 1'b0;
         armed   <= 1'b0;
      end else if (!pwr_good) begin
         seen_hi <= 1'b0;
         armed   <= 1'b0;
      end else begin
         if (ce_n) seen_hi <= 1'b1;
         if (!ce_n && seen_hi) armed <= 1'b1;
      end
   end

   // the first low cycle after a sampled high already counts
   assign ce_ok = armed | (seen_hi & ~ce_n);
endmodule

// File: rtl/nvsram_cmd_det.sv
module nvsram_cmd_det #(
   parameter int AW        = 4,
   parameter int KEY0      = 'hA,
   parameter int KEY1      = 'h5,
   parameter int OP_STORE  = 'h3,
   parameter int OP_RECALL = 'hC,
   parameter int OP_PF_ON  = 'h7,
   parameter int OP_PF_OFF = 'h8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic [AW-1:0] addr,
   output logic          cmd_store,
   output logic          cmd_recall,
   output logic          cmd_pf_on,
   output logic          cmd_pf_off
);
   localparam logic [AW-1:0] K0 = AW'(KEY0);
   localparam logic [AW-1:0] K1 = AW'(KEY1);

   logic [1:0] step;
   logic       at_op;

   assign at_op      = rd_stb && (step == 2'd2);
   assign cmd_store  = at_op && (addr == AW'(OP_STORE));
   assign cmd_recall = at_op && (addr == AW'(OP_RECALL));
   assign cmd_pf_on  = at_op && (addr == AW'(OP_PF_ON));
   assign cmd_pf_off = at_op && (addr == AW'(OP_PF_OFF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= 2'd0;
      end else if (wr_stb) begin
         step <= 2'd0;
      end else if (rd_stb) begin
         if (step == 2'd1 && addr == K1) step <= 2'd2;
         else if (addr == K0)            step <= 2'd1;
         else                            step <= 2'd0;
      end
   end
endmodule

// File: rtl/nvsram_xfer_seq.sv
module nvsram_xfer_seq
   import nvsram_pkg::*;
#(
   parameter int AW       = 4,
   parameter int XFER_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_store,
   input  logic          start_recall,
   input  logic          abort,
   output xfer_ph_t      phase,
   output logic [AW-1:0] widx,
   output logic          word_stb
);
   localparam int CW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1;

   logic running;
   assign running = (phase != PH_IDLE);

   generate
      if (XFER_LAT == 1) begin : g_single
         assign word_stb = running;
      end else begin : g_multi
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!running || abort)          cnt <= '0;
            else if (cnt == CW'(XFER_LAT - 1))   cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign word_stb = running && (cnt == CW'(XFER_LAT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         widx  <= '0;
      end else if (abort) begin
         phase <= PH_IDLE;
         widx  <= '0;
      end else if (phase == PH_IDLE) begin
         widx <= '0;
         if (start_store)       phase <= PH_ERASE;
         else if (start_recall) phase <= PH_CLEAR;
      end else if (word_stb) begin
         widx <= widx + 1'b1;
         if (&widx) phase <= next_phase(phase);
      end
   end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
   import nvsram_pkg::*;
#(
   parameter int AW        = 4,
   parameter int DW        = 8,
   parameter int XFER_LAT  = 2,
   parameter int KEY0      = 'hA,
   parameter int KEY1      = 'h5,
   parameter int OP_STORE  = 'h3,
   parameter int OP_RECALL = 'hC,
   parameter int OP_PF_ON  = 'h7,
   parameter int OP_PF_OFF = 'h8,
   parameter bit PF_EN_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_good,
   input  logic          pwr_fail,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_oe,
   input  logic          hs_n,
   output logic          busy_n,
   output logic [AW-1:0] last_wr_addr
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 2 || AW > 12 || DW < 1 || XFER_LAT < 1) begin : g_bad_size
         $error("nvsram_ctrl: size parameters out of range");
      end
      if (KEY0 == KEY1 || OP_STORE == OP_RECALL || OP_PF_ON == OP_PF_OFF ||
          OP_STORE == OP_PF_ON || OP_STORE == OP_PF_OFF ||
          OP_RECALL == OP_PF_ON || OP_RECALL == OP_PF_OFF) begin : g_bad_cmd
         $error("nvsram_ctrl: command addresses must be distinct");
      end
   endgenerate

   logic [DW-1:0] sram_q [DEPTH];
   logic [DW-1:0] nv_q   [DEPTH];

   xfer_ph_t      phase;
   logic [AW-1:0] widx;
   logic          word_stb;
   logic          ce_ok, idle, access, wr_stb, rd_stb;
   logic          cmd_store, cmd_recall, cmd_pf_on, cmd_pf_off;
   logic          pg_q, pf_q, hs_q, pf_en, rc_sw;
   logic          pg_rise, pf_rise, hs_fall;
   logic          start_store, start_recall, abort;

   nvsram_ce_gate u_gate (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .ce_ok(ce_ok)
   );

   assign idle   = (phase == PH_IDLE);
   assign access = pwr_good & ce_ok & ~ce_n & idle;
   assign wr_stb = access & ~we_n;
   assign rd_stb = access & we_n;

   nvsram_cmd_det #(
      .AW(AW), .KEY0(KEY0), .KEY1(KEY1), .OP_STORE(OP_STORE),
      .OP_RECALL(OP_RECALL), .OP_PF_ON(OP_PF_ON), .OP_PF_OFF(OP_PF_OFF)
   ) u_cmd (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
      .cmd_store(cmd_store), .cmd_recall(cmd_recall),
      .cmd_pf_on(cmd_pf_on), .cmd_pf_off(cmd_pf_off)
   );

   assign pg_rise = pwr_good & ~pg_q;
   assign pf_rise = pwr_fail & ~pf_q & pf_en;
   assign hs_fall = pwr_good & hs_q & ~hs_n;

   assign start_store  = idle & (pf_rise | hs_fall | cmd_store);
   assign start_recall = idle & (pg_rise | cmd_recall);
   assign abort        = rc_sw & pf_rise & ~idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q  <= 1'b0;
         pf_q  <= 1'b0;
         hs_q  <= 1'b1;
         pf_en <= PF_EN_RST;
         rc_sw <= 1'b0;
      end else begin
         pg_q <= pwr_good;
         pf_q <= pwr_fail;
         hs_q <= hs_n;
         if (cmd_pf_on)       pf_en <= 1'b1;
         else if (cmd_pf_off) pf_en <= 1'b0;
         if (idle) rc_sw <= cmd_recall & ~start_store;
      end
   end

   nvsram_xfer_seq #(.AW(AW), .XFER_LAT(XFER_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_store(start_store),
      .start_recall(start_recall), .abort(abort),
      .phase(phase), .widx(widx), .word_stb(word_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
      end else if (wr_stb) begin
         sram_q[addr] <= din;
      end else if (word_stb && phase == PH_CLEAR) begin
         sram_q[widx] <= '0;
      end else if (word_stb && phase == PH_RCOPY) begin
         sram_q[widx] <= nv_q[widx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) nv_q[i] <= '0;
      end else if (word_stb && phase == PH_ERASE) begin
         nv_q[widx] <= '0;
      end else if (word_stb && phase == PH_SCOPY) begin
         nv_q[widx] <= sram_q[widx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_wr_addr <= '0;
      else if (wr_stb) last_wr_addr <= addr;
   end

   assign dout_oe = rd_stb & ~oe_n;
   assign dout    = dout_oe ? sram_q[addr] : '0;
   assign busy_n  = idle;
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_good,
   input logic          pwr_fail,
   input logic          ce_n,
   input logic          we_n,
   input logic          hs_n,
   input logic          busy_n,
   input logic          dout_oe,
   input logic [AW-1:0] last_wr_addr,
   input logic          pf_en,
   input logic          rc_sw
);
   // R7
   busy_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> !dout_oe);

   // R2
   por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> !dout_oe);

   // R4
   last_addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_wr_addr != $past(last_wr_addr)) |->
         $past(!we_n && !ce_n && pwr_good && busy_n));

   // R9
   hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && pwr_good && $fell(hs_n)) |=> !busy_n);

   // R13
   pf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && rc_sw && pf_en && $rose(pwr_fail)) |=> busy_n);
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwr_fail(pwr_fail),
   .ce_n(ce_n), .we_n(we_n), .hs_n(hs_n), .busy_n(busy_n),
   .dout_oe(dout_oe), .last_wr_addr(last_wr_addr),
   .pf_en(pf_en), .rc_sw(rc_sw)
);

// File: tb/sim_nvsram_ctrl.sv
module sim_nvsram_ctrl;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int BUSY_CYC = 2 * (1 << AW) * 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_good = 1'b0;
   logic          pwr_fail = 1'b0;
   logic          ce_n = 1'b0;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_oe;
   logic          hs_n = 1'b1;
   logic          busy_n;
   logic [AW-1:0] last_wr_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   nvsram_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwr_fail(pwr_fail),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
      .dout(dout), .dout_oe(dout_oe), .hs_n(hs_n), .busy_n(busy_n),
      .last_wr_addr(last_wr_addr)
   );

   // {write, addr[3:0], data[7:0]}
   localparam logic [12:0] VEC [8] = '{
      {1'b1, 4'h0, 8'h11}, {1'b1, 4'h1, 8'h22}, {1'b1, 4'hF, 8'h33},
      {1'b0, 4'h0, 8'h11}, {1'b0, 4'h1, 8'h22}, {1'b0, 4'hF, 8'h33},
      {1'b1, 4'h1, 8'h44}, {1'b0, 4'h1, 8'h44}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_cyc();
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
   endtask

   task automatic rd_drive(input logic [AW-1:0] a);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      rd_drive(a);
      #1;
      check(req, {dout_oe, dout}, {1'b1, exp});
   endtask

   task automatic cmd(input logic [AW-1:0] op);
      rd_drive(4'hA);
      rd_drive(4'h5);
      rd_drive(op);
   endtask

   task automatic wait_busy(input int exp, input int pre, input string req);
      int cnt = pre;
      for (int i = 0; i < 400; i++) begin
         idle_cyc();
         #1;
         if (busy_n) break;
         cnt++;
      end
      check(req, cnt, exp);
   endtask

   task automatic stay_idle(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         idle_cyc();
         #1;
         check(req, busy_n, 1);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1 busy_n", busy_n, 1);
      check("R1 dout_oe", dout_oe, 0);
      check("R1 last_wr_addr", last_wr_addr, 0);
      rst_n = 1'b1;

      // R2 powered down: a read attempt is not driven
      rd_drive(4'h0);
      #1;
      check("R2 no output while unpowered", dout_oe, 0);

      // R11 power-up recall, ce_n held low
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      pwr_good = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         #1;
         if (busy_n) begin
            check("R11 power-up recall length", i, BUSY_CYC);
            break;
         end
      end

      // R2 not armed yet: write ignored, read not driven
      wr(4'h1, 8'h55);
      rd_drive(4'h1);
      #1;
      check("R2 unarmed read", dout_oe, 0);
      idle_cyc();
      rd(4'h1, 8'h00, "R2 unarmed write dropped");

      // R3 R4 vector table
      foreach (VEC[k]) begin
         if (VEC[k][12]) wr(VEC[k][11:8], VEC[k][7:0]);
         else            rd(VEC[k][11:8], VEC[k][7:0], "R3 table read");
      end
      idle_cyc();
      #1;
      check("R4 last_wr_addr", last_wr_addr, 1);

      // R9 R5 R7 hardware store, access attempts while busy
      @(negedge clk);
      hs_n = 1'b0;
      @(negedge clk);
      hs_n = 1'b1;
      #1;
      check("R9 hs_n starts store", busy_n, 0);
      wr(4'h0, 8'hEE);
      rd_drive(4'h0);
      #1;
      check("R7 no output while busy", dout_oe, 0);
      wait_busy(BUSY_CYC, 3, "R5 store length");
      rd(4'h0, 8'h11, "R7 write during busy dropped");
      check("R4 last_wr_addr unchanged by locked write", last_wr_addr, 1);

      // R8 R6 software recall restores stored data
      wr(4'h0, 8'h99);
      cmd(4'hC);
      wait_busy(BUSY_CYC, 0, "R6 recall length");
      rd(4'h0, 8'h11, "R6 R8 recall restores word 0");
      rd(4'h1, 8'h44, "R6 recall restores word 1");

      // R8 software store
      wr(4'h2, 8'h77);
      cmd(4'h3);
      wait_busy(BUSY_CYC, 0, "R8 software store length");
      wr(4'h2, 8'h00);
      cmd(4'hC);
      wait_busy(BUSY_CYC, 0, "R8 software recall length");
      rd(4'h2, 8'h77, "R8 stored word returns");

      // R8 broken sequence: a write between key reads
      rd_drive(4'hA);
      wr(4'h6, 8'h01);
      rd_drive(4'h5);
      rd_drive(4'h3);
      stay_idle(2, "R8 broken sequence ignored");

      // R10 power-fail store disabled, then enabled; R14 coincident write
      cmd(4'h8);
      idle_cyc();
      @(negedge clk);
      pwr_fail = 1'b1;
      stay_idle(4, "R10 disabled power-fail store");
      pwr_fail = 1'b0;
      cmd(4'h7);
      idle_cyc();
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 4'h3; din = 8'h3C;
      pwr_fail = 1'b1;
      wait_busy(BUSY_CYC, 0, "R10 power-fail store length");
      pwr_fail = 1'b0;
      check("R14 last_wr_addr", last_wr_addr, 3);
      wr(4'h3, 8'h00);
      cmd(4'hC);
      wait_busy(BUSY_CYC, 0, "R14 recall length");
      rd(4'h3, 8'h3C, "R14 coincident write was stored");

      // R12 store beats recall in the same cycle
      wr(4'h4, 8'h5A);
      rd_drive(4'hA);
      rd_drive(4'h5);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 4'hC;
      hs_n = 1'b0;
      wait_busy(BUSY_CYC, 0, "R12 collision length");
      hs_n = 1'b1;
      rd(4'h4, 8'h5A, "R12 store won, data kept");
      wr(4'h4, 8'h00);
      cmd(4'hC);
      wait_busy(BUSY_CYC, 0, "R12 recall length");
      rd(4'h4, 8'h5A, "R12 store captured word 4");

      // R12 hardware request during busy is dropped
      cmd(4'h3);
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      hs_n = 1'b0;
      wait_busy(BUSY_CYC, 1, "R12 busy store length");
      stay_idle(3, "R12 request during busy dropped");
      hs_n = 1'b1;
      stay_idle(2, "R12 rising hs_n no effect");

      // R13 power fail aborts a software recall; R6 clear runs first
      cmd(4'hC);
      for (int i = 0; i < 10; i++) idle_cyc();
      pwr_fail = 1'b1;
      idle_cyc();
      #1;
      check("R13 abort releases busy", busy_n, 1);
      stay_idle(3, "R13 no store after abort");
      pwr_fail = 1'b0;
      rd(4'h0, 8'h00, "R6 low words cleared first");
      rd(4'hF, 8'h33, "R6 high word untouched before abort");

      idle_cyc();
      finish_run();
   end
endmodule